// File: doc/BRIEF.md
# Two-Requester Bus Grant Controller

This block hands a shared bus to one of two requesters. Each requester raises its own request line. The block answers with a grant line per requester, and that grant enables the requester's bus drivers. The controller is a three-state synchronous Moore machine with an idle state, an A-owns state and a B-owns state. The grant outputs are decoded from the state register only, so they change only at a clock edge.

Ownership is sticky. A holder keeps the bus for as long as it requests, whatever the other side does. The bus passes across only when the holder has dropped its request and the other side is asking. When both sides request from idle, A wins. The state is held in two bits: idle is `00`, A-owns is `01` and B-owns is `11`. The unused code `10` returns to idle on the next edge and drives no grant while it is held. The parameter `USE_JK` chooses how the two state bits are built: plain data flip-flops, or JK flip-flops driven by excitation equations. Both builds must behave the same on every cycle.

Top module: `busgrant_fsm`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state becomes idle, and after that edge `gnt_a` = 0 and `gnt_b` = 0.
- R2: In any state, if `req_a` = 0 and `req_b` = 0 at an edge, then after that edge the machine is idle with both grants 0.
- R3: From idle, `req_a` = 1 at an edge gives `gnt_a` = 1 and `gnt_b` = 0 after that edge, whatever the value of `req_b`.
- R4: From idle, `req_a` = 0 and `req_b` = 1 give `gnt_a` = 0 and `gnt_b` = 1 after the edge.
- R5: While A owns the bus, `req_a` = 1 keeps A as owner, even when `req_b` = 1.
- R6: While A owns the bus, `req_a` = 0 and `req_b` = 1 hand the bus to B at the next edge.
- R7: While B owns the bus, `req_b` = 1 keeps B as owner, even when `req_a` = 1.
- R8: While B owns the bus, `req_a` = 1 and `req_b` = 0 hand the bus to A at the next edge.
- R9: `gnt_a` and `gnt_b` are never both 1, and each grant changes only at a rising clock edge.
- R10: The JK build (`USE_JK` = 1) and the data flip-flop build (`USE_JK` = 0) give the same grant outputs on every cycle for the same input sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, forces idle |
| req_a | input | 1 | Bus request from requester A |
| req_b | input | 1 | Bus request from requester B |
| gnt_a | output | 1 | Enables the bus drivers of requester A |
| gnt_b | output | 1 | Enables the bus drivers of requester B |

## Verification
The bench builds two copies of the block side by side: one with `USE_JK` = 0 and one with `USE_JK` = 1. Because of that, every cycle compares the two excitation styles against each other as well as against an arithmetic model. The bench steers the machine into each reachable state and then applies all four request patterns. This covers all twelve legal transitions, including the contested `11` case from each state. A long pseudo-random request stream follows, with resets scattered through it, to reach sequences of handovers that the sweep does not build on purpose.

// File: rtl/busgrant_pkg.sv
package busgrant_pkg;
   localparam int unsigned ST_W = 2;
   typedef logic [ST_W-1:0] st_t;
   // bit 1 marks B-side ownership, bit 0 marks "somebody owns"
   localparam st_t ST_IDLE = 2'b00;
   localparam st_t ST_OWNA = 2'b01;
   localparam st_t ST_OWNB = 2'b11;
   localparam st_t ST_HOLE = 2'b10;
endpackage

// File: rtl/busgrant_next.sv
module busgrant_next
   import busgrant_pkg::*;
#(
   parameter int unsigned USE_JK = 0
) (
   input  st_t  cur,
   input  logic req_a,
   input  logic req_b,
   output st_t  ctl_set,
   output st_t  ctl_clr
);
   localparam int unsigned NB = ST_W;

   logic any_req;
   assign any_req = req_a | req_b;

   generate
      if (USE_JK == 1) begin : g_jk
         // excitation equations: set pulls a 0 bit up, clr pulls a 1 bit down
         always_comb begin
            ctl_set[1] = req_b & ~req_a;
            ctl_clr[1] = ~req_b | ~cur[0];
            ctl_set[0] = any_req & ~cur[1];
            ctl_clr[0] = ~any_req;
         end
      end else begin : g_d
         st_t nxt;
         always_comb begin
            nxt[1] = req_b & ((~req_a & ~cur[1]) | (cur[1] & cur[0]));
            nxt[0] = any_req & (cur[0] | ~cur[1]);
            for (int i = 0; i < NB; i++) begin
               ctl_set[i] = nxt[i];
               ctl_clr[i] = ~nxt[i];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/busgrant_state_reg.sv
module busgrant_state_reg
   import busgrant_pkg::*;
#(
   parameter int unsigned USE_JK = 0
) (
   input  logic clk,
   input  logic rst,
   input  st_t  ctl_set,
   input  st_t  ctl_clr,
   output st_t  q
);
   localparam int unsigned NB = ST_W;

   generate
      for (genvar b = 0; b < NB; b++) begin : g_bit
         if (USE_JK == 1) begin : g_jk
            always_ff @(posedge clk) begin
               if (rst) q[b] <= ST_IDLE[b];
               else     q[b] <= (ctl_set[b] & ~q[b]) | (~ctl_clr[b] & q[b]);
            end
         end else begin : g_d
            always_ff @(posedge clk) begin
               if (rst) q[b] <= ST_IDLE[b];
               else     q[b] <= ctl_set[b];
            end
            // R10: data build must present complementary controls
            always_comb begin
               p_dctl_pair_r10: assert (ctl_clr[b] == ~ctl_set[b]);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/busgrant_decode.sv
module busgrant_decode
   import busgrant_pkg::*;
(
   input  st_t  st,
   output logic gnt_a,
   output logic gnt_b
);
   assign gnt_a = (st == ST_OWNA);
   assign gnt_b = (st == ST_OWNB);
endmodule

// File: rtl/busgrant_fsm.sv
module busgrant_fsm
   import busgrant_pkg::*;
#(
   parameter int unsigned USE_JK = 0
) (
   input  logic clk,
   input  logic rst,
   input  logic req_a,
   input  logic req_b,
   output logic gnt_a,
   output logic gnt_b
);
   generate
      if (USE_JK > 1) begin : g_bad_cfg
         $fatal(1, "USE_JK must be 0 or 1");
      end
   endgenerate

   st_t st, ctl_set, ctl_clr;

   busgrant_next #(.USE_JK(USE_JK)) u_next (
      .cur(st), .req_a(req_a), .req_b(req_b),
      .ctl_set(ctl_set), .ctl_clr(ctl_clr)
   );

   busgrant_state_reg #(.USE_JK(USE_JK)) u_reg (
      .clk(clk), .rst(rst), .ctl_set(ctl_set), .ctl_clr(ctl_clr), .q(st)
   );

   busgrant_decode u_dec (.st(st), .gnt_a(gnt_a), .gnt_b(gnt_b));

   p_reset_idle_r1: assert property (@(posedge clk)
      rst |=> (!gnt_a && !gnt_b));
   p_drop_idle_r2: assert property (@(posedge clk) disable iff (rst)
      (!req_a && !req_b) |=> (!gnt_a && !gnt_b));
   p_idle_to_a_r3: assert property (@(posedge clk) disable iff (rst)
      (!gnt_a && !gnt_b && req_a) |=> gnt_a);
   p_idle_to_b_r4: assert property (@(posedge clk) disable iff (rst)
      (!gnt_a && !gnt_b && !req_a && req_b) |=> gnt_b);
   p_hold_a_r5: assert property (@(posedge clk) disable iff (rst)
      (gnt_a && req_a) |=> gnt_a);
   p_pass_ab_r6: assert property (@(posedge clk) disable iff (rst)
      (gnt_a && !req_a && req_b) |=> gnt_b);
   p_hold_b_r7: assert property (@(posedge clk) disable iff (rst)
      (gnt_b && req_b) |=> gnt_b);
   p_pass_ba_r8: assert property (@(posedge clk) disable iff (rst)
      (gnt_b && req_a && !req_b) |=> gnt_a);
   p_mutex_r9: assert property (@(posedge clk)
      !(gnt_a && gnt_b));
   always_comb begin
      p_unused_silent_r9: assert (st != ST_HOLE || (!gnt_a && !gnt_b));
   end
endmodule

// File: tb/busgrant_fsm_bench.sv
`timescale 1ns/1ps
module busgrant_fsm_bench;
   logic clk = 1'b0;
   logic rst, req_a, req_b;
   logic gnt_a, gnt_b, gnt_a_jk, gnt_b_jk;
   int total = 0, bad = 0;
   int model = 0; // 0 idle, 1 A owns, 2 B owns
   bit finished = 0;

   always #2.5 clk = ~clk;

   busgrant_fsm #(.USE_JK(0)) u_busgrant_fsm (
      .clk(clk), .rst(rst), .req_a(req_a), .req_b(req_b),
      .gnt_a(gnt_a), .gnt_b(gnt_b));
   busgrant_fsm #(.USE_JK(1)) u_busgrant_fsm_jk (
      .clk(clk), .rst(rst), .req_a(req_a), .req_b(req_b),
      .gnt_a(gnt_a_jk), .gnt_b(gnt_b_jk));

   function automatic int model_next(int s, bit ia, bit ib);
      if (!ia && !ib) return 0;
      case (s)
         0: return ia ? 1 : 2;
         1: return ia ? 1 : 2;
         default: return ib ? 2 : 1;
      endcase
   endfunction

   task automatic check(string tag, logic [1:0] act, logic [1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: grants actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic step(bit r, bit ia, bit ib);
      string tag;
      logic [1:0] exp;
      logic [1:0] pre;
      @(negedge clk);
      rst = r; req_a = ia; req_b = ib;
      if (r) tag = "R1";
      else if (!ia && !ib) tag = "R2";
      else if (model == 0) tag = ia ? "R3" : "R4";
      else if (model == 1) tag = ia ? "R5" : "R6";
      else tag = ib ? "R7" : "R8";
      model = r ? 0 : model_next(model, ia, ib);
      exp = {model == 1, model == 2};
      pre = {gnt_a, gnt_b};
      #2.0;
      // R9: outputs must not move before the edge
      check("R9 stable", {gnt_a, gnt_b}, pre);
      @(negedge clk);
      check(tag, {gnt_a, gnt_b}, exp);
      check("R9 mutex", {1'b0, gnt_a & gnt_b}, 2'b00);
      check("R10 jk", {gnt_a_jk, gnt_b_jk}, {gnt_a, gnt_b});
   endtask

   task automatic goto_state(int s);
      step(1, 0, 0);
      if (s == 1) step(0, 1, 0);
      if (s == 2) step(0, 0, 1);
   endtask

   initial begin
      logic [15:0] lfsr;
      rst = 1'b1; req_a = 1'b0; req_b = 1'b0;
      // R1 right after reset
      step(1, 1, 1);
      // sweep every reachable state against every request pattern
      for (int s = 0; s < 3; s++) begin
         for (int p = 0; p < 4; p++) begin
            goto_state(s);
            step(0, p[1], p[0]);
         end
      end
      // R1 reset from a busy state
      goto_state(2);
      step(1, 0, 1);
      // pseudo-random stream
      lfsr = 16'hACE1;
      for (int n = 0; n < 3000; n++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step(lfsr[7:0] == 8'h5A, lfsr[3], lfsr[9]);
      end
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #200000;
      if (!finished) begin
         bad++;
         $display("FAIL watchdog: actual=expired expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule